// File: doc/BRIEF.md
# Master Time-Base Special Event Trigger

This block holds a free-running master time-base counter and a special-event compare unit. While the time base is enabled, the counter advances by one on every clock from zero up to a programmable period value and then returns to zero. Whenever the counter equals a programmable compare value, a compare event fires. A postscaler thins these events, so that only every N-th event, with N chosen from 1 to 16, produces a one-cycle trigger pulse to an analog-to-digital converter.

The same postscaled event can raise a one-cycle interrupt request when the interrupt enable is set. It also sets a sticky status flag that software can poll and clear by writing one. The trigger does not depend on the interrupt enable. A compare value beyond the period never fires. Dropping the time-base enable returns both the counter and the postscaler to zero. For example, a period of 4999 with a compare value of 1248 places the trigger about a quarter of the way into each period.

Top module: `mtb_sevt_gen`

## Requirements
- R1: While `tb_en` is high, the counter advances by one per clock from 0 up to `period` and then wraps to 0. With `ps_sel`=0 and a valid compare value, consecutive `trig_o` pulses are therefore `period`+1 cycles apart.
- R2: A compare event occurs when the counter equals `cmp_val`. After `tb_en` rises from a cleared state, with `ps_sel`=0, the first `trig_o` is visible `cmp_val`+1 clocks later.
- R3: `ps_sel` (4 bits, values 0 to 15) selects a ratio of 1:(`ps_sel`+1). Only every (`ps_sel`+1)-th compare event produces `trig_o`, so with a steady setup the pulses are (`ps_sel`+1)·(`period`+1) cycles apart.
- R4: `trig_o` is produced whatever the value of `irq_en`.
- R5: `irq_o` pulses exactly when `trig_o` pulses and `irq_en` is high. It stays low when `irq_en` is low.
- R6: Compare events are honoured only when `cmp_val` ≤ `period`. A `cmp_val` of exactly `period` still fires. A larger value never fires.
- R7: While `tb_en` is low, the counter and the postscaler count are held at 0. A partly filled postscaler is discarded when the time base is disabled.
- R8: `stat_o` is set in the same cycle as `trig_o` and stays set until `stat_clr` is high at a clock edge. If a new event and a clear coincide, the flag stays set.
- R9: `trig_o` and `irq_o` are single-cycle pulses, registered one clock after the counter holds the matching value.
- R10: After reset, `trig_o`, `irq_o` and `stat_o` are 0, and the counter and the postscaler start from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_en | input | 1 | Time-base enable; low holds counter and postscaler at 0 |
| period | input | CNT_W | Last counter value before wrap |
| cmp_val | input | CNT_W | Special-event compare value |
| ps_sel | input | 4 | Postscaler select, ratio 1:(ps_sel+1) |
| irq_en | input | 1 | Gates the interrupt request only |
| stat_clr | input | 1 | Write-one-to-clear for the status flag |
| trig_o | output | 1 | One-cycle converter trigger pulse |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| stat_o | output | 1 | Sticky special-event status flag |

## Verification
The delicate collision is a status-flag set and a software clear landing in the same cycle. The bench holds `stat_clr` high across a trigger, expects the flag to read one in the trigger cycle, and expects it to read zero on the next cycle. A second collision is a time-base disable arriving while the postscaler is partly filled. The bench disables after two of four required events and checks that the next trigger needs all four events again. A behavioural model, compared on every cycle, judges both cases.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  // Postscaler select width is fixed by the 1:1..1:16 ratio range
  localparam int unsigned PS_W = 4;

  typedef struct packed {
    logic match;  // counter equals compare value, compare in range
    logic roll;   // postscaler wraps: issue trigger
  } evt_t;
endpackage

// File: rtl/mtb_timebase.sv
module mtb_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  // Next counter value: wrap at or beyond the period
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return (c >= p) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!en) cnt_q <= '0;
    else          cnt_q <= next_count(cnt_q, period);
  end

  assign count = cnt_q;

  // R7
  tb_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/mtb_evt_post.sv
module mtb_evt_post #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [CNT_W-1:0]         count,
  input  logic [CNT_W-1:0]         period,
  input  logic [CNT_W-1:0]         cmp_val,
  input  logic [mtb_pkg::PS_W-1:0] ps_sel,
  output mtb_pkg::evt_t            evt
);
  import mtb_pkg::*;

  logic [PS_W-1:0] ps_q;
  logic            in_range;

  // Compare valid only inside the period
  function automatic logic cmp_ok(
    input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return c <= p;
  endfunction

  // Postscaler wraps when it has seen sel+1 events
  function automatic logic ps_wrap(
    input logic [PS_W-1:0] cnt, input logic [PS_W-1:0] sel);
    return cnt >= sel;
  endfunction

  assign in_range  = cmp_ok(cmp_val, period);
  assign evt.match = en && in_range && (count == cmp_val);
  assign evt.roll  = evt.match && ps_wrap(ps_q, ps_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ps_q <= '0;
    else if (!en)        ps_q <= '0;
    else if (evt.roll)   ps_q <= '0;
    else if (evt.match)  ps_q <= ps_q + 1'b1;
  end

  // R7
  ps_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ps_q == '0));
endmodule

// File: rtl/mtb_evt_status.sv
module mtb_evt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic roll,
  input  logic irq_en,
  input  logic clr,
  output logic trig,
  output logic irq,
  output logic stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= 1'b0;
      irq  <= 1'b0;
      stat <= 1'b0;
    end else begin
      trig <= roll;
      irq  <= roll && irq_en;
      if (roll)     stat <= 1'b1;
      else if (clr) stat <= 1'b0;
    end
  end

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr) |=> stat);
endmodule

// File: rtl/mtb_sevt_gen.sv
module mtb_sevt_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tb_en,
  input  logic [CNT_W-1:0]         period,
  input  logic [CNT_W-1:0]         cmp_val,
  input  logic [mtb_pkg::PS_W-1:0] ps_sel,
  input  logic                     irq_en,
  input  logic                     stat_clr,
  output logic                     trig_o,
  output logic                     irq_o,
  output logic                     stat_o
);
  import mtb_pkg::*;

  logic [CNT_W-1:0] tb_count;
  evt_t             sevt;

  mtb_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(tb_en), .period(period), .count(tb_count)
  );

  mtb_evt_post #(.CNT_W(CNT_W)) u_post (
    .clk(clk), .rst_n(rst_n), .en(tb_en), .count(tb_count),
    .period(period), .cmp_val(cmp_val), .ps_sel(ps_sel), .evt(sevt)
  );

  mtb_evt_status u_stat (
    .clk(clk), .rst_n(rst_n), .roll(sevt.roll), .irq_en(irq_en),
    .clr(stat_clr), .trig(trig_o), .irq(irq_o), .stat(stat_o)
  );

  // R5
  irq_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> trig_o);

  // R8
  stat_with_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> stat_o);

  // R6
  trig_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(cmp_val) <= $past(period) && $past(tb_en)));

  // R9
  trig_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sevt.roll |=> trig_o);
endmodule

// File: tb/test_mtb_sevt_gen.sv
module test_mtb_sevt_gen;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tb_en = 1'b0;
  logic [CW-1:0] period = '0;
  logic [CW-1:0] cmp_val = '0;
  logic [3:0]    ps_sel = '0;
  logic          irq_en = 1'b0;
  logic          stat_clr = 1'b0;
  logic          trig_o, irq_o, stat_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // reference model state
  int  m_cnt = 0, m_ps = 0;
  bit  m_trig = 0, m_irq = 0, m_stat = 0;

  always #2.5 clk = ~clk;

  mtb_sevt_gen #(.CNT_W(CW)) i_mtb_sevt_gen (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .period(period),
    .cmp_val(cmp_val), .ps_sel(ps_sel), .irq_en(irq_en),
    .stat_clr(stat_clr), .trig_o(trig_o), .irq_o(irq_o), .stat_o(stat_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ps = 0; m_trig = 0; m_irq = 0; m_stat = 0;
    end else begin
      bit hit, fire;
      hit  = tb_en && (m_cnt == int'(cmp_val)) && (int'(cmp_val) <= int'(period));
      fire = hit && (m_ps >= int'(ps_sel));
      m_trig = fire;
      m_irq  = fire && irq_en;
      if (fire) m_stat = 1;
      else if (stat_clr) m_stat = 0;
      if (!tb_en) m_ps = 0;
      else if (fire) m_ps = 0;
      else if (hit) m_ps = m_ps + 1;
      if (!tb_en) m_cnt = 0;
      else m_cnt = (m_cnt >= int'(period)) ? 0 : m_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 trig_o vs model", trig_o, m_trig);
      chk("R5 irq_o vs model", irq_o, m_irq);
      chk("R8 stat_o vs model", stat_o, m_stat);
    end
  end

  task automatic wait_trig(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trig_o && n < lim);
    if (!trig_o) n = -1;
  endtask

  task automatic restart();
    @(negedge clk); tb_en = 1'b0;
    @(negedge clk); tb_en = 1'b1;
  endtask

  initial begin
    int n, cnt_t, cnt_i;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 trig_o in reset", trig_o, 0);
    chk("R10 irq_o in reset", irq_o, 0);
    chk("R10 stat_o in reset", stat_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 stat_o after reset", stat_o, 0);

    period = 9; cmp_val = 3; ps_sel = 0; irq_en = 1;
    @(negedge clk); tb_en = 1'b1;
    wait_trig(100, n);
    chk("R2 first trigger delay", n, 4);
    chk("R5 irq with trigger", irq_o, 1);
    @(negedge clk);
    chk("R9 trig_o single cycle", trig_o, 0);
    chk("R9 irq_o single cycle", irq_o, 0);
    wait_trig(100, n);
    chk("R1 trigger interval", n, 9);
    wait_trig(100, n);
    chk("R1 trigger interval steady", n, 10);

    // R3: 1:3 postscaler
    ps_sel = 2; restart();
    wait_trig(200, n);
    wait_trig(200, n);
    chk("R3 postscaled interval 1:3", n, 30);
    ps_sel = 15;
    wait_trig(400, n);
    wait_trig(400, n);
    chk("R3 postscaled interval 1:16", n, 160);

    // R4 / R5: interrupt enable off
    ps_sel = 0; irq_en = 0; restart();
    cnt_t = 0; cnt_i = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      cnt_t += trig_o; cnt_i += irq_o;
    end
    chk("R4 triggers with irq_en low", cnt_t, 5);
    chk("R5 no irq with irq_en low", cnt_i, 0);
    irq_en = 1;

    // R6: compare beyond period, and at period
    cmp_val = 10; restart();
    cnt_t = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); cnt_t += trig_o; end
    chk("R6 out-of-range compare silent", cnt_t, 0);
    cmp_val = 9; restart();
    wait_trig(100, n);
    chk("R6 compare equal to period fires", n, 10);

    // R7: disable discards partial postscaler
    cmp_val = 3; ps_sel = 3; restart();
    repeat (15) @(negedge clk);
    tb_en = 1'b0;
    repeat (2) @(negedge clk);
    tb_en = 1'b1;
    wait_trig(200, n);
    chk("R7 postscaler cleared by disable", n, 34);

    // R8: clear, then clear colliding with an event
    ps_sel = 0;
    wait_trig(100, n);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk("R8 clear drops status", stat_o, 0);
    repeat (3) @(negedge clk);
    chk("R8 status stays clear", stat_o, 0);
    stat_clr = 1'b1;
    wait_trig(100, n);
    chk("R8 set wins over clear", stat_o, 1);
    @(negedge clk);
    chk("R8 held clear after event", stat_o, 0);
    stat_clr = 1'b0;
    wait_trig(100, n);
    repeat (4) @(negedge clk);
    chk("R8 status sticky", stat_o, 1);

    // R10: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 status cleared by reset", stat_o, 0);
    rst_n = 1'b1;
    wait_trig(100, n);
    chk("R10 counter restarts at zero", n, 4);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule